// File: doc/BRIEF.md
# Bus-Phase Memory Strobe Generator

This block is the glue between a processor bus with a multiplexed bank byte and a set of static memories and peripherals. A fast system clock `clk` samples the processor's phase-2 clock, the read/write line and the two valid-address flags. It also samples the 8-bit data bus and the 16-bit address bus. While phase-2 is low the data bus carries the bank byte. The block captures that byte and joins it to the 16-bit address to form a 24-bit address. It then decodes the 24-bit address into three active-low chip selects for RAM, ROM and I/O.

Chip selects go active during the low half of phase-2, as soon as a valid address is present. Because the address is held until after the next falling edge, a chip select stays active through the high half. The read strobe and the write strobe are separate active-low outputs. They are released only while phase-2 is high, and they are never active together. No memory is asked to drive the data bus while the processor is placing the bank byte on it. A peripheral that needs exclusive read and write controls can share the same strobes.

The control core is a two-state phase machine. The states are `PH_LOW` and `PH_HIGH`. The transition `RISE` (`PH_LOW` to `PH_HIGH`) is taken when phase-2 is sampled high, and it closes the bank capture. The transition `FALL` (`PH_HIGH` to `PH_LOW`) is taken when phase-2 is sampled low, and it reopens the capture. Reset forces `PH_LOW`. Every output is registered and reflects the inputs sampled at the previous `clk` edge.

Top module: `phase_strobe_gen`

## Requirements
- R1: While `rst_n` is low, all chip selects and both strobes are high (inactive) and `bus_addr` is 0.
- R2: `oe_n` is low exactly when, at the previous `clk` edge, `phi2` was 1 and `rw_n` was 1.
- R3: `we_n` is low exactly when, at the previous `clk` edge, `phi2` was 1 and `rw_n` was 0.
- R4: `oe_n` and `we_n` are never low together. Neither strobe is low in a cycle that follows a `phi2` = 0 sample.
- R5: At every `clk` edge where `phi2` is 0, the bank byte is taken from `data_in`. At edges where `phi2` is 1, the last such byte is held. `bus_addr` equals {bank, `addr_in`}, where the bank is `data_in` itself during the low phase and the held byte during the high phase.
- R6: If `vda` and `vpa` were both 0 at the previous edge, all three chip selects are high, while the strobes still follow R2 and R3.
- R7: `rom_cs_n` is low for a valid address in $00E000–$00FFFF. ROM has priority over RAM.
- R8: `io_cs_n` is low for a valid address in $00C000–$00DFFF. I/O has priority over RAM.
- R9: `ram_cs_n` is low for a valid address in $000000–$07FFFF that is in neither the ROM window nor the I/O window. An address above $07FFFF selects nothing.
- R10: At most one chip select is low in any cycle.
- R11: A chip select is already low in the cycle after a low-phase sample with a valid, mapped address. It stays low through the high phase while the address and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock level |
| rw_n | input | 1 | Read (1) / write (0) line |
| vda | input | 1 | Valid data address flag |
| vpa | input | 1 | Valid program address flag |
| data_in | input | 8 | Data bus; carries the bank byte while phi2 is low |
| addr_in | input | 16 | Low 16 address bits |
| bus_addr | output | 24 | Registered full 24-bit address |
| ram_cs_n | output | 1 | Active-low RAM select |
| rom_cs_n | output | 1 | Active-low ROM select |
| io_cs_n | output | 1 | Active-low I/O select |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |

## Verification
Every result is due exactly one `clk` edge after the inputs that cause it are sampled. This holds for the selects, the strobes and the assembled address. The driver applies each input set at a falling `clk` edge and queues the expected outputs at that moment. The monitor compares one queued item shortly after each rising edge, so each item is checked against the first registered response to its stimulus. The bench's bank model is updated only after an item's address is computed. This reproduces the rule that a high-phase cycle uses the byte held from the last low-phase sample.

// File: rtl/psg_pkg.sv
package psg_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
    } region_sel_t;

endpackage

// File: rtl/psg_bank_capture.sv
module psg_bank_capture #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              phase_high_i,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_eff_o
);
    logic [BANK_W-1:0] bank_q;

    // Latch model: follows the bus while open, holds once closed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (open_i) begin
            bank_q <= data_i;
        end
    end

    assign bank_eff_o = open_i ? data_i : bank_q;

    // R5: the held byte cannot move while the phase stays high.
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_high_i && $past(phase_high_i)) |-> $stable(bank_q));

endmodule

// File: rtl/psg_region_decode.sv
module psg_region_decode
    import psg_pkg::*;
#(
    parameter int              ADDR_W = 24,
    parameter logic [ADDR_W-1:0] RAM_LO = 'h000000,
    parameter logic [ADDR_W-1:0] RAM_HI = 'h07FFFF,
    parameter logic [ADDR_W-1:0] ROM_LO = 'h00E000,
    parameter logic [ADDR_W-1:0] ROM_HI = 'h00FFFF,
    parameter logic [ADDR_W-1:0] IO_LO  = 'h00C000,
    parameter logic [ADDR_W-1:0] IO_HI  = 'h00DFFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    output region_sel_t       sel_o
);
    logic hit_ram, hit_rom, hit_io;

    always_comb begin
        hit_ram = (addr_i >= RAM_LO) && (addr_i <= RAM_HI);
        hit_rom = (addr_i >= ROM_LO) && (addr_i <= ROM_HI);
        hit_io  = (addr_i >= IO_LO)  && (addr_i <= IO_HI);
        // Priority: ROM, then I/O, then RAM.
        sel_o.rom = valid_i && hit_rom;
        sel_o.io  = valid_i && hit_io && !hit_rom;
        sel_o.ram = valid_i && hit_ram && !hit_rom && !hit_io;
    end

endmodule

// File: rtl/phase_strobe_gen.sv
module phase_strobe_gen
    import psg_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFFS_W = 16,
    parameter logic [BANK_W+OFFS_W-1:0] RAM_LO = 'h000000,
    parameter logic [BANK_W+OFFS_W-1:0] RAM_HI = 'h07FFFF,
    parameter logic [BANK_W+OFFS_W-1:0] ROM_LO = 'h00E000,
    parameter logic [BANK_W+OFFS_W-1:0] ROM_HI = 'h00FFFF,
    parameter logic [BANK_W+OFFS_W-1:0] IO_LO  = 'h00C000,
    parameter logic [BANK_W+OFFS_W-1:0] IO_HI  = 'h00DFFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phi2,
    input  logic                     rw_n,
    input  logic                     vda,
    input  logic                     vpa,
    input  logic [BANK_W-1:0]        data_in,
    input  logic [OFFS_W-1:0]        addr_in,
    output logic [BANK_W+OFFS_W-1:0] bus_addr,
    output logic                     ram_cs_n,
    output logic                     rom_cs_n,
    output logic                     io_cs_n,
    output logic                     oe_n,
    output logic                     we_n
);
    localparam int ADDR_W = BANK_W + OFFS_W;

    phase_e            state_q, state_d;
    logic [BANK_W-1:0] bank_eff;
    logic [ADDR_W-1:0] addr_full;
    region_sel_t       sel;

    // Next phase: RISE and FALL transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (phi2)  state_d = PH_HIGH;  // RISE
            PH_HIGH: if (!phi2) state_d = PH_LOW;   // FALL
            default: state_d = PH_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    psg_bank_capture #(.BANK_W(BANK_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (state_d == PH_LOW),
        .phase_high_i (state_q == PH_HIGH),
        .data_i       (data_in),
        .bank_eff_o   (bank_eff)
    );

    assign addr_full = {bank_eff, addr_in};

    psg_region_decode #(
        .ADDR_W (ADDR_W),
        .RAM_LO (RAM_LO), .RAM_HI (RAM_HI),
        .ROM_LO (ROM_LO), .ROM_HI (ROM_HI),
        .IO_LO  (IO_LO),  .IO_HI  (IO_HI)
    ) u_dec (
        .addr_i  (addr_full),
        .valid_i (vda || vpa),
        .sel_o   (sel)
    );

    // Output process: selects early, strobes gated by the high phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
            ram_cs_n <= 1'b1;
            rom_cs_n <= 1'b1;
            io_cs_n  <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
        end else begin
            bus_addr <= addr_full;
            ram_cs_n <= !sel.ram;
            rom_cs_n <= !sel.rom;
            io_cs_n  <= !sel.io;
            unique case (state_d)
                PH_LOW: begin
                    oe_n <= 1'b1;
                    we_n <= 1'b1;
                end
                PH_HIGH: begin
                    oe_n <= !rw_n;
                    we_n <= rw_n;
                end
                default: begin
                    oe_n <= 1'b1;
                    we_n <= 1'b1;
                end
            endcase
        end
    end

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_strobe_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> (state_q == PH_HIGH));

    assert_onehot_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ram_cs_n, !rom_cs_n, !io_cs_n}));

    assert_cs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n || !rom_cs_n || !io_cs_n) |-> $past(vda || vpa));

endmodule

// File: tb/phase_strobe_gen_tb.sv
`timescale 1ns/1ps
module phase_strobe_gen_tb;

    typedef struct {
        logic        ram_n, rom_n, io_n, oe_n, we_n;
        logic [23:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, phi2 = 1'b0, rw_n = 1'b1, vda = 1'b0, vpa = 1'b0;
    logic [7:0]  data_in = '0;
    logic [15:0] addr_in = '0;
    logic [23:0] bus_addr;
    logic        ram_cs_n, rom_cs_n, io_cs_n, oe_n, we_n;

    exp_t        q[$];
    logic [7:0]  m_bank = '0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    phase_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw_n(rw_n), .vda(vda), .vpa(vpa),
        .data_in(data_in), .addr_in(addr_in), .bus_addr(bus_addr),
        .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
        .oe_n(oe_n), .we_n(we_n)
    );

    // Driver: apply one input set and queue the response due after the next rising edge.
    task automatic step(input logic rst, input logic ph, input logic rw,
                        input logic va, input logic vp, input logic [7:0] d,
                        input logic [15:0] a, input string tag);
        exp_t e;
        logic [23:0] fa;
        logic        ok, rom, io, ram;
        @(negedge clk);
        rst_n = !rst; phi2 = ph; rw_n = rw; vda = va; vpa = vp; data_in = d; addr_in = a;
        e.tag = tag;
        if (rst) begin
            m_bank = '0;
            e.ram_n = 1; e.rom_n = 1; e.io_n = 1; e.oe_n = 1; e.we_n = 1; e.addr = '0;
        end else begin
            fa  = {ph ? m_bank : d, a};
            ok  = va || vp;
            rom = ok && fa >= 24'h00E000 && fa <= 24'h00FFFF;
            io  = ok && fa >= 24'h00C000 && fa <= 24'h00DFFF;
            ram = ok && fa <= 24'h07FFFF && !rom && !io;
            e.ram_n = !ram; e.rom_n = !rom; e.io_n = !io;
            e.oe_n  = !(ph && rw);
            e.we_n  = !(ph && !rw);
            e.addr  = fa;
            if (!ph) m_bank = d;
        end
        q.push_back(e);
    endtask

    task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] a, input logic rw,
                             input logic va, input logic vp, input int nlo, input int nhi,
                             input string tag);
        for (int i = 0; i < nlo; i++) step(0, 0, rw, va, vp, bank, a, tag);
        for (int i = 0; i < nhi; i++) step(0, 1, rw, va, vp, 8'($urandom), a, tag);
    endtask

    // Monitor: compare one queued item just after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if ({ram_cs_n, rom_cs_n, io_cs_n, oe_n, we_n} !== {e.ram_n, e.rom_n, e.io_n, e.oe_n, e.we_n}
                    || bus_addr !== e.addr) begin
                    n_bad++;
                    $display("FAIL %s: got cs=%b%b%b oe=%b we=%b addr=%h, want cs=%b%b%b oe=%b we=%b addr=%h",
                             e.tag, ram_cs_n, rom_cs_n, io_cs_n, oe_n, we_n, bus_addr,
                             e.ram_n, e.rom_n, e.io_n, e.oe_n, e.we_n, e.addr);
                end
                n_chk++;
                if (!oe_n && !we_n) begin // R4 overlap check on every cycle
                    n_bad++;
                    $display("FAIL R4: got oe_n=%b we_n=%b, want not both 0", oe_n, we_n);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, 8'hAA, 16'hE000, "R1");
        bus_cycle(8'h01, 16'h2345, 1, 1, 0, 3, 3, "R9_R2_R11");
        bus_cycle(8'h00, 16'hF000, 1, 0, 1, 2, 4, "R7_R2");
        bus_cycle(8'h00, 16'hC010, 0, 1, 0, 3, 3, "R8_R3");
        bus_cycle(8'h00, 16'hE000, 0, 1, 1, 2, 2, "R7_edge");
        bus_cycle(8'h00, 16'hDFFF, 1, 1, 0, 2, 2, "R8_edge");
        bus_cycle(8'h00, 16'hBFFF, 0, 1, 0, 2, 2, "R9_low");
        bus_cycle(8'h07, 16'hFFFF, 1, 1, 0, 2, 2, "R9_top");
        bus_cycle(8'h08, 16'h0000, 1, 1, 0, 2, 2, "R9_unmapped");
        bus_cycle(8'h00, 16'hF000, 1, 0, 0, 2, 3, "R6_read");
        bus_cycle(8'h00, 16'h1000, 0, 0, 0, 2, 3, "R6_write");
        bus_cycle(8'h05, 16'h8000, 1, 0, 1, 4, 5, "R5_hold");
        for (int n = 0; n < 1500; n++)
            bus_cycle(8'($urandom_range(0, 9)), 16'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), $urandom_range(1, 4),
                      $urandom_range(1, 4), "R4_R10_rand");
        step(1, 0, 1, 1, 0, 8'h00, 16'h0000, "R1_again");
        step(0, 0, 1, 0, 0, 8'h00, 16'h0000, "R1_release");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule